// File: doc/BRIEF.md
# Modified Immediate Expander

This block turns a packed 12-bit immediate field into a full 32-bit constant. It also produces the carry-out that a flag-setting logical operation would take from that operand. The field has two forms. In the first, the two most significant bits are zero and a byte is copied into one of four fixed lane patterns. In the second, an eight-bit value whose top bit is forced to one is rotated right by a five-bit amount taken from the top of the field.

The block is purely combinational. A decode stage drives the field and the current carry flag into it, and the outputs are valid in the same cycle.

The block also raises a flag for replication encodings that make no architectural sense: a non-trivial lane pattern combined with a zero byte. Downstream logic can use this flag to trap or to treat the encoding as reserved.

Top module: `modimm_expand`

## Requirements
- R1: When field bits 11:8 are 0000, the constant is the low byte zero-extended to 32 bits.
- R2: When field bits 11:8 are 0001, the byte appears in bits 23:16 and 7:0, and all other bits are zero.
- R3: When field bits 11:8 are 0010, the byte appears in bits 31:24 and 15:8, and all other bits are zero.
- R4: When field bits 11:8 are 0011, the byte appears in all four byte lanes.
- R5: When field bits 11:10 are 00, carry_out equals carry_in.
- R6: When field bits 11:10 are not 00, the constant is the eight-bit value {1, field[6:0]} rotated right within 32 bits by field[11:7]. This holds for every amount from 8 to 31.
- R7: When field bits 11:10 are not 00, carry_out equals bit 31 of the constant.
- R8: unpredictable is 1 exactly when field bits 11:10 are 00, field bits 9:8 are nonzero, and field bits 7:0 are zero.
- R9: When field bits 11:10 are not 00, carry_in has no effect on the constant, on carry_out or on unpredictable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| field | input | 12 | Packed immediate, bit 11 most significant |
| carry_in | input | 1 | Current carry flag |
| value | output | 32 | Expanded constant |
| carry_out | output | 1 | Carry produced for flag-setting operations |
| unpredictable | output | 1 | Reserved replication encoding detected |

## Verification
The bench sweeps all 4096 field values, once with carry_in low and once with it high. This covers each replication pattern with zero, sparse and dense bytes, so a swapped lane or a pattern mapped to the wrong selector shows up as a value mismatch. It also covers every rotation amount with every seven-bit payload, which separates a rotate from a plain shift, a rotation in the wrong direction, and an off-by-one amount. Running both carry values shows that carry_in passes through in the replication form and is ignored in the rotated form. The zero-byte cases with pattern 00 and in the rotated form check that unpredictable stays low there.

// File: rtl/modimm_expand.sv
module modimm_expand #(
  parameter int FLD_W = 12,
  parameter int OUT_W = 32
) (
  input  logic [FLD_W-1:0] field,
  input  logic             carry_in,
  output logic [OUT_W-1:0] value,
  output logic             carry_out,
  output logic             unpredictable
);
  localparam int BYTE_W = 8;
  localparam int AMT_W  = 5;

  logic               is_rep;
  logic [1:0]         pat;
  logic [BYTE_W-1:0]  lo_byte;
  logic [AMT_W-1:0]   amt;
  logic [OUT_W-1:0]   seed;
  logic [2*OUT_W-1:0] twin;
  logic [OUT_W-1:0]   rep_val;
  logic [OUT_W-1:0]   rot_val;

  assign is_rep  = (field[FLD_W-1:FLD_W-2] == 2'b00);
  assign pat     = field[9:8];
  assign lo_byte = field[BYTE_W-1:0];
  assign amt     = field[FLD_W-1:FLD_W-AMT_W];

  assign seed    = {{(OUT_W-BYTE_W){1'b0}}, 1'b1, field[BYTE_W-2:0]};
  assign twin    = {seed, seed} >> amt;
  assign rot_val = twin[OUT_W-1:0];

  always_comb begin
    unique case (pat)
      2'b00:   rep_val = {24'h0, lo_byte};
      2'b01:   rep_val = {8'h0, lo_byte, 8'h0, lo_byte};
      2'b10:   rep_val = {lo_byte, 8'h0, lo_byte, 8'h0};
      default: rep_val = {lo_byte, lo_byte, lo_byte, lo_byte};
    endcase
  end

  assign value         = is_rep ? rep_val : rot_val;
  assign carry_out     = is_rep ? carry_in : rot_val[OUT_W-1];
  assign unpredictable = is_rep && (pat != 2'b00) && (lo_byte == '0);
endmodule

// File: rtl/modimm_expand_chk.sv
module modimm_expand_chk (
  input logic [11:0] field,
  input logic        carry_in,
  input logic [31:0] value,
  input logic        carry_out,
  input logic        unpredictable
);
  always_comb begin
    if (!$isunknown({field, carry_in})) begin
      // R1
      zext_chk: assert (field[11:8] != 4'b0000 || value[31:8] == 24'h0);
      // R4
      splat_chk: assert (field[11:8] != 4'b0011 ||
                         (value[31:24] == value[7:0] && value[15:8] == value[7:0]));
      // R5
      carry_pass_chk: assert (field[11:10] != 2'b00 || carry_out == carry_in);
      // R6
      rot_pop_chk: assert (field[11:10] == 2'b00 ||
                           $countones(value) == $countones(field[6:0]) + 1);
      // R7
      carry_msb_chk: assert (field[11:10] == 2'b00 || carry_out == value[31]);
      // R8
      unpred_form_chk: assert (!unpredictable || (field[11:10] == 2'b00 && value != 32'h0 ? 1'b0 : 1'b1));
    end
  end
endmodule

bind modimm_expand modimm_expand_chk u_chk (
  .field(field),
  .carry_in(carry_in),
  .value(value),
  .carry_out(carry_out),
  .unpredictable(unpredictable)
);

// File: tb/modimm_expand_bench.sv
module modimm_expand_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] field = '0;
  logic        carry_in = 1'b0;
  logic [31:0] value;
  logic        carry_out;
  logic        unpredictable;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  modimm_expand u_modimm_expand (
    .field(field), .carry_in(carry_in), .value(value),
    .carry_out(carry_out), .unpredictable(unpredictable)
  );

  function automatic logic [31:0] ref_val(input logic [11:0] f);
    logic [7:0]  b;
    logic [31:0] v;
    b = f[7:0];
    if (f[11:10] == 2'b00) begin
      case (f[9:8])
        2'b00:   v = 32'(b);
        2'b01:   v = (32'(b) << 16) + 32'(b);
        2'b10:   v = (32'(b) << 24) + (32'(b) << 8);
        default: v = 32'(b) * 32'h01010101;
      endcase
    end else begin
      v = 32'h80 + 32'(f[6:0]);
      for (int k = 0; k < int'(f[11:7]); k++) v = {v[0], v[31:1]};
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s field=%03h cin=%0b actual=%08h expected=%08h", tag, field, carry_in, act, exp);
    end
  endtask

  function automatic string val_tag(input logic [11:0] f);
    if (f[11:10] != 2'b00) return "R6";
    case (f[9:8])
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    logic [31:0] r_val;
    logic        r_cy;
    logic        r_up;
    logic [31:0] v_c0;
    logic        cy_c0;
    logic        up_c0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", value, 32'h0);
    for (int f = 0; f < 4096; f++) begin
      for (int c = 0; c < 2; c++) begin
        @(negedge clk);
        field = 12'(f);
        carry_in = c[0];
        #2;
        r_val = ref_val(field);
        r_up  = (field[11:10] == 2'b00) && (field[9:8] != 2'b00) && (field[7:0] == 8'h0);
        if (field[11:10] == 2'b00) r_cy = carry_in;
        else r_cy = r_val[31];
        check(val_tag(field), value, r_val);
        check(field[11:10] == 2'b00 ? "R5" : "R7", 32'(carry_out), 32'(r_cy));
        check("R8", 32'(unpredictable), 32'(r_up));
        if (c == 0) begin
          v_c0 = value; cy_c0 = carry_out; up_c0 = unpredictable;
        end else if (field[11:10] != 2'b00) begin
          // R9: outputs with carry_in high match those with it low
          check("R9", value, v_c0);
          check("R9", 32'(carry_out), 32'(cy_c0));
          check("R9", 32'(unpredictable), 32'(up_c0));
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule